// File: doc/BRIEF.md
# Transport Stream PID Filter

This block screens MPEG transport stream packets on two independent byte streams. Each stream has its own drop map with one bit for every possible 13-bit packet identifier. A set bit discards every packet carrying that identifier, and a clear bit lets the packet through unchanged. The identifier is read from the low five bits of header byte 1 and all of header byte 2. Identifiers 0 to 31 carry system tables, so they are never blocked, whatever the map says.

Software reaches the maps through three byte-wide registers. One register holds identifier bits 10..3. A second holds identifier bits 12..11 and the channel number. The third is a data window onto the addressed map byte. The window can be read back, so software changes one identifier's bit by reading the byte, editing it and writing it back. Writing 0xFF to every map byte of a channel passes only system traffic on that channel. Writing zero to every byte passes the whole stream.

Each stream carries bytes with a valid strobe and a start-of-packet flag. The output runs three accepted input bytes behind the input, because the first byte cannot leave before the identifier in bytes 1 and 2 has been looked up.

Top module: `ts_pid_filter`

## Requirements
- R1: `cfg_sel` selects a register: 0 is the index low register, 1 is the index high register, 2 is the data window and 3 reads zero. The low register stores all 8 bits. The high register stores bits 2..0, where bits 1..0 are identifier bits 12..11 and bit 2 is the channel. Both registers read back what was written, and unused high bits read 0.
- R2: A write to the data window stores the byte at map index {high[1:0], low} of the selected channel. A read of the window returns that stored byte in the same cycle.
- R3: Map bytes 0 to 3 of each channel ignore writes and always read as zero.
- R4: A packet starts with `s_sop`. Its identifier is {byte1[4:0], byte2}. If bit (identifier mod 8) of map byte (identifier / 8) is 1, every byte of the packet is dropped. If that bit is 0, every byte is forwarded unchanged, with `m_sop` marking the first byte.
- R5: Packets with identifiers 0 to 31 are forwarded whatever the map holds.
- R6: A packet whose first byte is not 0x47 is dropped completely.
- R7: Output byte k of a stream leaves on the `m_*` port in the cycle after the input cycle that accepts stream byte k+3. Idle cycles between input bytes are allowed and do not change the byte order.
- R8: Each channel filters with its own map only.
- R9: Bytes that arrive after reset and before the first `s_sop` are dropped. A packet whose next start flag arrives within its first three bytes is dropped.
- R10: After reset, `m_valid` is 0 and both index registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the register picked by `cfg_sel` |
| cfg_sel | input | 2 | Register select (0 index low, 1 index high, 2 data window) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| s_valid | input | 2 | Input byte valid, one bit per channel |
| s_data | input | 2x8 | Input byte per channel |
| s_sop | input | 2 | First byte of a packet, per channel |
| m_valid | output | 2 | Output byte valid per channel |
| m_data | output | 2x8 | Output byte per channel |
| m_sop | output | 2 | Output first byte of a packet per channel |

## Verification
The bench drives a deliberately fragmented input: loose bytes before any start flag, a two-byte runt that is cut off by the next packet, a bad sync byte, idle gaps inside packets, and header bytes whose upper bits are set. A design that waits for the wrong number of bytes, or that takes more than five identifier bits from byte 1, shifts or misroutes whole packets, and the per-cycle comparison catches it. Read-modify-write of a single bit sits between identifiers that share the same map byte, so a wrong bit index blocks the neighbouring identifier instead of the target. A map byte below index 4, written with 0xFF on a channel whose map otherwise blocks everything, must still let system identifiers through. A design without that guard would block system traffic.

// File: rtl/ts_pf_pkg.sv
package ts_pf_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h47;

    typedef enum logic [1:0] {
        SEL_IDX_LO = 2'd0,
        SEL_IDX_HI = 2'd1,
        SEL_WINDOW = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        HDR_IDLE = 2'd0,
        HDR_B1   = 2'd1,
        HDR_B2   = 2'd2
    } hdr_e;

    typedef struct packed {
        logic [7:0] data;
        logic       sop;
        logic       occ;
    } slot_t;

endpackage

// File: rtl/pid_bitmap.sv
module pid_bitmap #(
    parameter int IDX_W     = 10,
    parameter int ZERO_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] cfg_idx,
    output logic [7:0]       cfg_byte,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [7:0]       lk_byte
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] ZLIM = IDX_W'(ZERO_BYTES);

    logic [7:0] map_mem [DEPTH];
    logic [7:0] lk_d, lk_q;

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx >= ZLIM))
            map_mem[wr_idx] <= wr_byte;
    end

    assign cfg_byte = (cfg_idx < ZLIM) ? 8'h00 : map_mem[cfg_idx];

    always_comb begin
        lk_d = lk_q;
        if (lk_en)
            lk_d = (lk_idx < ZLIM) ? 8'h00 : map_mem[lk_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign lk_byte = lk_q;

    // R3
    low_bytes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && (lk_idx < ZLIM)) |=> (lk_byte == 8'h00));

endmodule

// File: rtl/ts_chan_filter.sv
module ts_chan_filter
    import ts_pf_pkg::*;
#(
    parameter int PID_W    = 13,
    parameter int SYS_PIDS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    output logic             lk_en,
    output logic [PID_W-4:0] lk_idx,
    input  logic [7:0]       lk_byte,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop
);
    localparam int DLY  = 3;
    localparam int HI_W = PID_W - 8;
    localparam logic [PID_W-1:0] SYS_LIM = PID_W'(SYS_PIDS);

    typedef struct packed {
        slot_t [DLY-1:0]  stg;
        hdr_e             hdr;
        logic [HI_W-1:0]  pid_hi;
        logic             sync_ok;
        logic             sys;
        logic [2:0]       bsel;
        logic             pass;
        logic             ov;
        logic [7:0]       od;
        logic             os;
    } st_t;

    st_t   d, q;
    slot_t oldest;
    logic  runt;
    logic  keep;

    assign lk_en  = in_valid && !in_sop && (q.hdr == HDR_B2);
    assign lk_idx = {q.pid_hi, in_data[7:3]};

    always_comb begin
        d      = q;
        d.ov   = 1'b0;
        oldest = q.stg[DLY-1];
        runt   = in_sop;
        for (int i = 0; i < DLY-1; i++)
            runt = runt | q.stg[i].sop;
        keep = q.pass;
        if (in_valid) begin
            if (oldest.occ && oldest.sop) begin
                keep = !runt && q.sync_ok && (q.sys || !lk_byte[q.bsel]);
                d.pass = keep;
            end
            d.ov = oldest.occ && keep;
            d.od = oldest.data;
            d.os = oldest.sop;
            for (int i = DLY-1; i > 0; i--)
                d.stg[i] = q.stg[i-1];
            d.stg[0] = '{data: in_data, sop: in_sop, occ: 1'b1};
            if (in_sop) begin
                d.hdr     = HDR_B1;
                d.sync_ok = (in_data == SYNC_BYTE);
            end else begin
                case (q.hdr)
                    HDR_B1: begin
                        d.pid_hi = in_data[HI_W-1:0];
                        d.hdr    = HDR_B2;
                    end
                    HDR_B2: begin
                        d.sys  = ({q.pid_hi, in_data} < SYS_LIM);
                        d.bsel = in_data[2:0];
                        d.hdr  = HDR_IDLE;
                    end
                    default: d.hdr = HDR_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_sop   = q.os;

    // R7
    out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R6
    sop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data == SYNC_BYTE));

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
    import ts_pf_pkg::*;
#(
    parameter int CHANNELS = 2,
    parameter int PID_W    = 13,
    parameter int SYS_PIDS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [1:0]               cfg_sel,
    input  logic [7:0]               cfg_wdata,
    output logic [7:0]               cfg_rdata,
    input  logic [CHANNELS-1:0]      s_valid,
    input  logic [CHANNELS-1:0][7:0] s_data,
    input  logic [CHANNELS-1:0]      s_sop,
    output logic [CHANNELS-1:0]      m_valid,
    output logic [CHANNELS-1:0][7:0] m_data,
    output logic [CHANNELS-1:0]      m_sop
);
    localparam int IDX_W    = PID_W - 3;
    localparam int HI_PID_W = PID_W - 11;
    localparam int CH_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
    localparam int HI_REG_W = HI_PID_W + CH_W;

    typedef struct packed {
        logic [7:0]          lo;
        logic [HI_REG_W-1:0] hi;
    } cfg_t;

    cfg_t d, q;

    logic [IDX_W-1:0]          win_idx;
    logic [CH_W-1:0]           ch_sel;
    logic [CHANNELS-1:0][7:0]  win_byte;
    logic [7:0]                win_rd;

    assign win_idx = {q.hi[HI_PID_W-1:0], q.lo};
    assign ch_sel  = q.hi[HI_PID_W +: CH_W];

    always_comb begin
        d = q;
        if (cfg_wr) begin
            if (cfg_sel == SEL_IDX_LO) d.lo = cfg_wdata;
            if (cfg_sel == SEL_IDX_HI) d.hi = cfg_wdata[HI_REG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        win_rd = 8'h00;
        for (int i = 0; i < CHANNELS; i++)
            if (ch_sel == CH_W'(i)) win_rd = win_byte[i];
    end

    always_comb begin
        case (cfg_sel)
            SEL_IDX_LO: cfg_rdata = q.lo;
            SEL_IDX_HI: cfg_rdata = 8'(q.hi);
            SEL_WINDOW: cfg_rdata = win_rd;
            default:    cfg_rdata = 8'h00;
        endcase
    end

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        logic             lk_en;
        logic [IDX_W-1:0] lk_idx;
        logic [7:0]       lk_byte;
        logic             wr_here;

        assign wr_here = cfg_wr && (cfg_sel == SEL_WINDOW) && (ch_sel == CH_W'(g));

        pid_bitmap #(.IDX_W(IDX_W), .ZERO_BYTES(SYS_PIDS / 8)) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_here),
            .wr_idx   (win_idx),
            .wr_byte  (cfg_wdata),
            .cfg_idx  (win_idx),
            .cfg_byte (win_byte[g]),
            .lk_en    (lk_en),
            .lk_idx   (lk_idx),
            .lk_byte  (lk_byte)
        );

        ts_chan_filter #(.PID_W(PID_W), .SYS_PIDS(SYS_PIDS)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (s_valid[g]),
            .in_data   (s_data[g]),
            .in_sop    (s_sop[g]),
            .lk_en     (lk_en),
            .lk_idx    (lk_idx),
            .lk_byte   (lk_byte),
            .out_valid (m_valid[g]),
            .out_data  (m_data[g]),
            .out_sop   (m_sop[g])
        );
    end

    // R1
    idx_lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_sel == SEL_IDX_LO)) |=> (q.lo == $past(cfg_wdata)));

    // R1
    idx_hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_sel == SEL_IDX_HI)) |=> (q.hi == $past(cfg_wdata[HI_REG_W-1:0])));

endmodule

// File: tb/ts_pid_filter_test.sv
module ts_pid_filter_test;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 1'b0;
    logic [1:0]      cfg_sel = 2'd3;
    logic [7:0]      cfg_wdata = 8'h00;
    logic [7:0]      cfg_rdata;
    logic [1:0]      s_valid = 2'b00;
    logic [1:0][7:0] s_data = '0;
    logic [1:0]      s_sop = 2'b00;
    logic [1:0]      m_valid;
    logic [1:0][7:0] m_data;
    logic [1:0]      m_sop;

    ts_pid_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .s_valid(s_valid),
        .s_data(s_data), .s_sop(s_sop), .m_valid(m_valid), .m_data(m_data),
        .m_sop(m_sop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    string      tag = "R10";
    logic [8:0] hist [2][$];
    bit [7:0]   tbl [2][1024];
    bit         cur_pass [2];
    bit         exp_v [2];
    logic [7:0] exp_d [2];
    bit         exp_s [2];
    logic [7:0] m_lo = 8'h00;
    logic [2:0] m_hi = 3'd0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic step(input logic [1:0] v, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [1:0] s, input bit w, input logic [1:0] sel,
                        input logic [7:0] wd);
        logic [7:0] dd [2];
        @(negedge clk);
        for (int ch = 0; ch < 2; ch++) begin
            check(m_valid[ch] == exp_v[ch] &&
                  (!exp_v[ch] || (m_data[ch] == exp_d[ch] && m_sop[ch] == exp_s[ch])),
                  tag, {m_valid[ch], m_sop[ch], m_data[ch]},
                  {exp_v[ch], exp_s[ch], exp_d[ch]});
        end
        dd[0] = d0;
        dd[1] = d1;
        for (int ch = 0; ch < 2; ch++) begin
            exp_v[ch] = 1'b0;
            if (v[ch]) begin
                hist[ch].push_back({s[ch], dd[ch]});
                if (hist[ch].size() > 3) begin
                    logic [8:0] e;
                    e = hist[ch].pop_front();
                    if (e[8]) begin
                        int  pid;
                        bit  runt;
                        runt = hist[ch][0][8] | hist[ch][1][8] | hist[ch][2][8];
                        pid  = {hist[ch][0][4:0], hist[ch][1][7:0]};
                        cur_pass[ch] = !runt && (e[7:0] == 8'h47) &&
                                       (pid < 32 || tbl[ch][pid >> 3][pid & 7] == 1'b0);
                    end
                    exp_v[ch] = cur_pass[ch];
                    exp_d[ch] = e[7:0];
                    exp_s[ch] = e[8];
                end
            end
        end
        if (w) begin
            if (sel == 2'd0) m_lo = wd;
            if (sel == 2'd1) m_hi = wd[2:0];
            if (sel == 2'd2) begin
                int idx;
                idx = {m_hi[1:0], m_lo};
                if (idx >= 4) tbl[m_hi[2]][idx] = wd;
            end
        end
        s_valid = v; s_data[0] = d0; s_data[1] = d1; s_sop = s;
        cfg_wr = w; cfg_sel = sel; cfg_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'b00, 8'h00, 8'h00, 2'b00, 1'b0, 2'd3, 8'h00);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        step(2'b00, 8'h00, 8'h00, 2'b00, 1'b1, sel, val);
    endtask

    task automatic point(input int ch, input int idx);
        wr(2'd0, idx[7:0]);
        wr(2'd1, {5'd0, ch[0], idx[9:8]});
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        step(2'b00, 8'h00, 8'h00, 2'b00, 1'b0, sel, 8'h00);
        #1 val = cfg_rdata;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [7:0] expv, input string req);
        logic [7:0] got;
        rd(sel, got);
        check(got == expv, req, got, expv);
    endtask

    task automatic fill(input int ch, input logic [7:0] val);
        for (int i = 0; i < 1024; i++) begin
            point(ch, i);
            wr(2'd2, val);
        end
    endtask

    task automatic pkts(input int pid0, input int pid1, input logic [1:0] en,
                        input logic [7:0] sync, input int len, input int gap);
        for (int b = 0; b < len; b++) begin
            logic [7:0] bb [2];
            int pp [2];
            pp[0] = pid0; pp[1] = pid1;
            for (int ch = 0; ch < 2; ch++) begin
                if (b == 0)      bb[ch] = sync;
                else if (b == 1) bb[ch] = {3'b010, pp[ch][12:8]};
                else if (b == 2) bb[ch] = pp[ch][7:0];
                else             bb[ch] = 8'((b * 7) + (ch * 13));
            end
            step(en, bb[0], bb[1], (b == 0) ? en : 2'b00, 1'b0, 2'd3, 8'h00);
            if (gap > 0) idle(gap);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        for (int c = 0; c < 2; c++) begin
            cur_pass[c] = 1'b0; exp_v[c] = 1'b0; exp_d[c] = 8'h00; exp_s[c] = 1'b0;
            for (int i = 0; i < 1024; i++) tbl[c][i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1;
        check(m_valid == 2'b00, "R10 valid", m_valid, 0);
        @(negedge clk) rst_n = 1'b1;

        tag = "R10";
        rd_chk(2'd0, 8'h00, "R10 idx_lo");
        rd_chk(2'd1, 8'h00, "R10 idx_hi");

        tag = "R1";
        wr(2'd0, 8'hA5);
        rd_chk(2'd0, 8'hA5, "R1 idx_lo");
        wr(2'd1, 8'hFF);
        rd_chk(2'd1, 8'h07, "R1 idx_hi");
        rd_chk(2'd3, 8'h00, "R1 sel3");

        tag = "R2";
        fill(0, 8'h00);
        fill(1, 8'hFF);
        point(0, 'h155);
        wr(2'd2, 8'h3C);
        rd_chk(2'd2, 8'h3C, "R2 window");
        wr(2'd2, 8'h00);
        point(1, 'h155);
        rd_chk(2'd2, 8'hFF, "R8 map_ch1");

        tag = "R3";
        point(1, 2);
        rd_chk(2'd2, 8'h00, "R3 ch1_byte2");
        point(1, 0);
        wr(2'd2, 8'hFF);
        rd_chk(2'd2, 8'h00, "R3 ch1_byte0");

        tag = "R9 stray";
        for (int i = 0; i < 5; i++) step(2'b11, 8'h47, 8'h47, 2'b00, 1'b0, 2'd3, 8'h00);

        tag = "R4 pass";
        pkts('h100, 'h100, 2'b11, 8'h47, 188, 0);
        tag = "R5 sys";
        pkts('h005, 'h01F, 2'b11, 8'h47, 188, 0);
        tag = "R4 drop";
        pkts('h1FFF, 'h020, 2'b11, 8'h47, 188, 0);

        tag = "R4 rmw";
        point(0, 'h123 >> 3);
        rd(2'd2, b);
        wr(2'd2, b | 8'h08);
        rd_chk(2'd2, 8'h08, "R4 rmw");
        pkts('h123, 'h00, 2'b01, 8'h47, 188, 0);
        pkts('h122, 'h00, 2'b01, 8'h47, 188, 0);
        pkts('h124, 'h00, 2'b01, 8'h47, 188, 0);

        tag = "R6";
        pkts('h100, 'h005, 2'b11, 8'h46, 188, 0);
        pkts('h100, 'h005, 2'b11, 8'h47, 188, 0);

        tag = "R7 gaps";
        pkts('h200, 'h010, 2'b11, 8'h47, 188, 2);

        tag = "R9 runt";
        pkts('h200, 'h010, 2'b11, 8'h47, 2, 0);
        pkts('h201, 'h011, 2'b11, 8'h47, 188, 1);

        tag = "R8";
        point(1, 'h300 >> 3);
        wr(2'd2, 8'h00);
        pkts('h300, 'h300, 2'b11, 8'h47, 188, 0);
        pkts('h300, 'h301, 2'b11, 8'h47, 188, 0);
        pkts('h100, 'h100, 2'b10, 8'h47, 188, 0);
        idle(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule